// File: doc/BRIEF.md
# PLL Lock-Gated Reset Sequencer

This block produces a processor reset line that also reports phase lock. It runs in the Q-rate clock domain, the divided output clock of a PLL. It takes an asynchronous active-low reset request and a lock flag that the PLL delivers synchronously. The reset stays asserted while the request is low or the PLL is unlocked. Once both conditions clear, it stays asserted for a fixed number of Q-rate cycles (1024 by default) and is then released.

The output behaves as an open-drain pin. `pull_low` enables the low driver, and `released` shows that the pin is floating and an external pull-up holds it high. Nothing ever drives the line high. Because the release depends on lock, a released line also tells the system that the PLL has locked. A later request pulse or a loss of lock pulls the line low again and restarts the hold interval from zero.

The controller is a four-state Moore machine:
- `ST_REQ_HELD`: the request is active.
- `ST_WAIT_LOCK`: the request is inactive and the PLL is unlocked.
- `ST_HOLD_COUNT`: both conditions are met and the hold counter is running.
- `ST_RELEASED`: the line is floating.

The transitions are:
- any state to `ST_REQ_HELD` when the synchronized request is low.
- `ST_REQ_HELD` to `ST_HOLD_COUNT` when the request goes high with lock present.
- `ST_REQ_HELD` to `ST_WAIT_LOCK` when the request goes high without lock.
- `ST_WAIT_LOCK` to `ST_HOLD_COUNT` when lock arrives.
- `ST_HOLD_COUNT` to `ST_WAIT_LOCK` when lock is lost.
- `ST_HOLD_COUNT` to `ST_RELEASED` when the count reaches its last value.
- `ST_RELEASED` to `ST_WAIT_LOCK` when lock is lost.

Top module: `lockrst_seq`

## Requirements
- R1: While the synchronized request is high and `pll_locked` is low, `pull_low` is 1 from the next clock edge on.
- R2: When `pll_locked` is first sampled high with the synchronized request high, `released` becomes 1 after the 1024th following clock edge (`HOLD_CYCLES` = 1024), and `pull_low` stays 1 until then.
- R3: `released` is 1 exactly when `pull_low` is 0. The block has no output that drives the line high.
- R4: A change on `req_n` passes through a two-flop synchronizer and takes effect on the third clock edge after the change. After `req_n` returns high with lock present, `released` rises 1024 edges after that third edge.
- R5: While the synchronized request stays low, including from power-up, `pull_low` stays 1 whatever `pll_locked` does.
- R6: If `pll_locked` falls while released, `pull_low` is 1 after the next clock edge.
- R7: If `pll_locked` falls during the hold count, the count restarts from zero when lock returns. The release then comes 1024 edges after the edge at which lock is again sampled high.
- R8: `por_n` low forces the request-held state at once, with `pull_low` = 1. The synchronizer then reads the request as low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Q-rate clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| req_n | input | 1 | Asynchronous reset request, active low |
| pll_locked | input | 1 | PLL lock flag, synchronous to clk |
| pull_low | output | 1 | Enables the open-drain low driver |
| released | output | 1 | Line is floating and pulled high externally |

## Verification
- **Request changes:** these cross two synchronizer flops and the state register. A change on `req_n` driven before edge n shows on the outputs after edge n+3.
- **Lock changes:** a change on `pll_locked` reaches the state register directly, so it shows after edge n+1.
- **Release timing:** the release appears exactly 1024 edges after the counting state is entered.
- **How checks are timed:** the driver task computes each due cycle from these latencies and queues the expected value with that cycle number. The monitor compares on the falling edge of that exact cycle. Probes sit one cycle before and at each boundary, so an off-by-one error in either direction is caught.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
    typedef enum logic [1:0] {
        ST_REQ_HELD   = 2'd0,
        ST_WAIT_LOCK  = 2'd1,
        ST_HOLD_COUNT = 2'd2,
        ST_RELEASED   = 2'd3
    } lrs_state_t;
endpackage

// File: rtl/lrs_sync.sv
module lrs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge por_n) begin
                    if (!por_n) chain[0] <= 1'b0;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge por_n) begin
                    if (!por_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/lrs_holdcnt.sv
module lrs_holdcnt #(
    parameter int LIMIT = 1024,
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          run,
    output logic [CW-1:0] count,
    output logic          at_last
);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)       count <= '0;
        else if (!run)    count <= '0;
        else if (!at_last) count <= count + 1'b1;
    end

    assign at_last = (count == LAST);

    // R7: a stopped counter always restarts from zero
    a_r7_restart_zero: assert property (@(posedge clk) disable iff (!por_n)
        !run |=> (count == '0));
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!por_n)
        count <= LAST);
endmodule

// File: rtl/lockrst_seq.sv
module lockrst_seq #(
    parameter int HOLD_CYCLES = 1024,
    parameter int SYNC_STAGES = 2,
    localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1
) (
    input  logic clk,
    input  logic por_n,
    input  logic req_n,
    input  logic pll_locked,
    output logic pull_low,
    output logic released
);
    import lrs_pkg::*;

    lrs_state_t state, state_nx;
    logic          req_s;
    logic          run;
    logic          at_last;
    logic [CW-1:0] count;

    lrs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .por_n   (por_n),
        .d_async (req_n),
        .q_sync  (req_s)
    );

    assign run = (state == ST_HOLD_COUNT) && pll_locked && req_s;

    lrs_holdcnt #(.LIMIT(HOLD_CYCLES)) u_cnt (
        .clk     (clk),
        .por_n   (por_n),
        .run     (run),
        .count   (count),
        .at_last (at_last)
    );

    always_comb begin
        state_nx = state;
        if (!req_s) begin
            state_nx = ST_REQ_HELD;
        end else begin
            unique case (state)
                ST_REQ_HELD:   state_nx = pll_locked ? ST_HOLD_COUNT : ST_WAIT_LOCK;
                ST_WAIT_LOCK:  if (pll_locked) state_nx = ST_HOLD_COUNT;
                ST_HOLD_COUNT: if (!pll_locked) state_nx = ST_WAIT_LOCK;
                               else if (at_last) state_nx = ST_RELEASED;
                ST_RELEASED:   if (!pll_locked) state_nx = ST_WAIT_LOCK;
                default:       state_nx = ST_REQ_HELD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state <= ST_REQ_HELD;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_RELEASED: begin pull_low = 1'b0; released = 1'b1; end
            default:     begin pull_low = 1'b1; released = 1'b0; end
        endcase
    end

    a_r1_unlocked_low: assert property (@(posedge clk) disable iff (!por_n)
        (req_s && !pll_locked) |=> pull_low);
    a_r5_request_holds: assert property (@(posedge clk) disable iff (!por_n)
        !req_s |=> pull_low);
    a_r2_full_count: assert property (@(posedge clk) disable iff (!por_n)
        $rose(released) |-> ($past(count) == CW'(HOLD_CYCLES - 1)));
    a_r6_release_needs_lock: assert property (@(posedge clk) disable iff (!por_n)
        $rose(released) |-> $past(pll_locked));
    a_r3_one_of_two: assert property (@(posedge clk) disable iff (!por_n)
        $countones({pull_low, released}) == 1);
endmodule

// File: tb/test_lockrst_seq.sv
module test_lockrst_seq;
    localparam int HOLD = 1024;

    typedef struct {
        int    cyc;
        logic  exp_low;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic req_n = 1'b0;
    logic pll_locked = 1'b1;
    logic pull_low, released;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lockrst_seq i_lockrst_seq (
        .clk        (clk),
        .por_n      (por_n),
        .req_n      (req_n),
        .pll_locked (pll_locked),
        .pull_low   (pull_low),
        .released   (released)
    );

    function automatic void expect_at(int c, logic v, string t);
        exp_t e;
        e.cyc = c; e.exp_low = v; e.tag = t;
        sb.push_back(e);
    endfunction

    task automatic go_to(int n);
        while (cyc != n) @(negedge clk);
    endtask

    // monitor: compare queued expectations at their due cycle
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (e.cyc != cyc || pull_low !== e.exp_low) begin
                errors++;
                $display("FAIL %s cyc %0d: pull_low=%b expected %b", e.tag, e.cyc, pull_low, e.exp_low);
            end
            checks++;
            if (released !== ~e.exp_low) begin // R3
                errors++;
                $display("FAIL R3 cyc %0d: released=%b expected %b", e.cyc, released, ~e.exp_low);
            end
        end
    end

    initial begin
        // R8 reset state, R5 request held low at power-up
        expect_at(2, 1'b1, "R8");
        expect_at(5, 1'b1, "R5");
        expect_at(40, 1'b1, "R5");
        go_to(3); por_n = 1'b1;
        // R4/R2: request released with lock present
        go_to(50);
        expect_at(50 + 2 + HOLD, 1'b1, "R4");
        expect_at(50 + 3 + HOLD, 1'b0, "R4");
        req_n = 1'b1;
        // R6: lock lost while released, R1 unlocked holds low
        go_to(1100);
        expect_at(1100, 1'b0, "R6");
        expect_at(1101, 1'b1, "R6");
        expect_at(1105, 1'b1, "R1");
        pll_locked = 1'b0;
        // R2 lock returns; R7 one-cycle glitch restarts count
        go_to(1110);
        expect_at(1110 + 1 + HOLD, 1'b1, "R7");
        expect_at(1600 + 1 + HOLD, 1'b1, "R7");
        expect_at(1600 + 2 + HOLD, 1'b0, "R7");
        pll_locked = 1'b1;
        go_to(1600); pll_locked = 1'b0;
        go_to(1601); pll_locked = 1'b1;
        // R4: short request pulse while released
        go_to(2700);
        expect_at(2702, 1'b0, "R4");
        expect_at(2703, 1'b1, "R4");
        expect_at(2704 + 2 + HOLD, 1'b1, "R4");
        expect_at(2704 + 3 + HOLD, 1'b0, "R4");
        req_n = 1'b0;
        go_to(2704); req_n = 1'b1;
        // R5: request held low while lock toggles
        go_to(3800);
        expect_at(3803, 1'b1, "R5");
        expect_at(3815, 1'b1, "R5");
        expect_at(3820, 1'b1, "R5");
        expect_at(3830, 1'b1, "R5");
        req_n = 1'b0;
        for (int k = 0; k < 20; k++) begin
            go_to(3810 + k);
            pll_locked = ~pll_locked;
        end
        go_to(3840);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: cycle %0d expected completion before 50000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule